// File: doc/BRIEF.md
# CompactFlash Socket Presence and Card Reset Controller

This block watches the two card-detect contacts of a CompactFlash socket and decides whether a card is seated. A card is counted as present only while both contacts read low; with either contact high the socket is treated as empty. Each contact is brought into the clock domain by a two-flop synchronizer and then passed through a stable-level filter, so a level must hold for `FILT_LEN` consecutive cycles before it is believed. Every change of the present state raises a one-cycle event toward the interrupt logic and sets a sticky status-changed flag.

The block also owns the card reset output. Software can hold reset asserted by leaving a control bit set, or it can request a timed pulse of `PULSE_LEN` clock cycles (the default is 200 us at 125 MHz). A fresh insertion seen while the host is enabled fires the same pulse by itself. A host-enable bit gates all of this. Clearing it drops the status flag, aborts a running pulse and silences events. Setting it again restarts from a clean state.

Software reaches the block through a two-register read/write port: status when `reg_sel` is 0 and control when it is 1. Reads are combinational; writes take effect at the clock edge where `reg_we` is high. The port has no data stream, so it carries no valid/ready handshake.

Top module: `cf_detect_reset`

## Requirements
- R1: `card_present` is 1 only when both filtered detect levels are 0; if either is 1, it is 0.
- R2: A detect level that changes for fewer than `FILT_LEN` cycles (the bench uses a 4-cycle glitch with `FILT_LEN`=8) changes neither `card_present` nor the status pin bits, and raises no event.
- R3: `det_event` is a single-cycle pulse, raised exactly once for each change of `card_present` while the host is enabled. A change of contact levels that leaves the present state as it was raises no event.
- R4: After reset, `card_present` takes its value from the settled contact levels without raising an event. The status flag and all control bits reset to 0.
- R5: Status read (`reg_sel`=0) returns bit 0 = status-changed flag, bit 2 = filtered contact A, bit 3 = filtered contact B, bit 5 = synchronized card-ready pin, bit 6 = synchronized I/O-ready pin. All other bits read 0.
- R6: The status-changed flag is set by each event. A status write with bit 0 = 1 clears it, and a status write with bit 0 = 0 leaves it unchanged.
- R7: Control bits [1:0] drive `card_mode` (0 memory, 1 I/O, 2 true IDE), bit 3 holds `card_rst` high for as long as it is set, and bit 4 is host enable (`host_en`). A control read returns these bits in the same places, with all other bits 0.
- R8: A control write with bit 7 = 1 and bit 4 = 1 produces a `card_rst` pulse exactly `PULSE_LEN` cycles long. Bit 7 is not stored and reads back as 0.
- R9: An absent-to-present change while the host is enabled starts a `PULSE_LEN`-cycle reset pulse. A present-to-absent change does not.
- R10: While host enable is 0, no event is raised, the status flag reads 0, and pulse requests and insertions produce no reset pulse. Clearing host enable during a pulse ends the pulse at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_a_pin | input | 1 | Raw card-detect contact A (low when seated) |
| det_b_pin | input | 1 | Raw card-detect contact B (low when seated) |
| rdy_pin | input | 1 | Raw card-ready level |
| io_rdy_pin | input | 1 | Raw I/O-ready level |
| reg_sel | input | 1 | Register select: 0 status, 1 control |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| card_present | output | 1 | Filtered present state |
| det_event | output | 1 | One-cycle presence-change event |
| card_rst | output | 1 | Card reset output, active high |
| card_mode | output | 2 | Selected card mode |
| host_en | output | 1 | Host enable bit |

## Verification
The assertions assume that the contact inputs never toggle faster than the filter can settle, so two presence changes cannot come on consecutive cycles; the bench always holds each contact level for far longer than `FILT_LEN` before it changes it again. The pulse-length bound assumes that the only restart sources are a pulse-request write and an insertion event, and the checker tracks exactly those. Every pin and register stimulus is driven on the falling clock edge, so each stimulus meets a single rising edge in a known state.

// File: rtl/cfdr_pkg.sv
package cfdr_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    MODE_MEMORY = 2'd0,
    MODE_IO     = 2'd1,
    MODE_IDE    = 2'd2,
    MODE_RSVD   = 2'd3
  } card_mode_e;

  // status bit positions, decoded by software
  localparam int ST_CHANGED = 0;
  localparam int ST_DET_A   = 2;
  localparam int ST_DET_B   = 3;
  localparam int ST_READY   = 5;
  localparam int ST_IO_RDY  = 6;

  // control bit positions
  localparam int CT_MODE_LO = 0;
  localparam int CT_HOLD    = 3;
  localparam int CT_HOST_EN = 4;
  localparam int CT_PULSE   = 7;

  localparam int NUM_DET = 2;

  typedef struct packed {
    logic       host_en;
    logic       hold;
    card_mode_e mode;
  } ctrl_t;

endpackage

// File: rtl/cfdr_sync2.sv
module cfdr_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cfdr_pin_filter.sv
module cfdr_pin_filter #(
  parameter int FILT_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic level,
  output logic settled
);
  localparam int CNT_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);

  logic             s_pin;
  logic             s_hist;
  logic [CNT_W-1:0] run_cnt;

  cfdr_sync2 #(.W(1), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (s_pin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_hist  <= 1'b1;
      run_cnt <= '0;
      level   <= 1'b1;
      settled <= 1'b0;
    end else begin
      s_hist <= s_pin;
      if (s_pin != s_hist) begin
        run_cnt <= '0;
      end else if (run_cnt != LAST) begin
        run_cnt <= run_cnt + 1'b1;
      end
      if ((s_pin == s_hist) && (run_cnt == LAST)) begin
        level   <= s_pin;
        settled <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfdr_presence.sv
module cfdr_presence #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] settled,
  input  logic         host_en,
  output logic         present,
  output logic         event_p
);
  logic primed;
  logic seated_now;

  assign seated_now = (lvl == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      present <= 1'b0;
      event_p <= 1'b0;
    end else begin
      event_p <= 1'b0;
      if (!primed) begin
        if (&settled) begin
          primed  <= 1'b1;
          present <= seated_now;
        end
      end else if (seated_now != present) begin
        present <= seated_now;
        event_p <= host_en;
      end
    end
  end
endmodule

// File: rtl/cfdr_rst_gen.sv
module cfdr_rst_gen #(
  parameter int PULSE_LEN = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enabled,
  input  logic abort,
  input  logic start,
  input  logic hold,
  output logic rst_out
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (!enabled || abort) begin
      remain <= '0;
    end else if (start) begin
      remain <= LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign rst_out = hold | (remain != '0);
endmodule

// File: rtl/cf_detect_reset.sv
module cf_detect_reset
  import cfdr_pkg::*;
#(
  parameter int FILT_LEN  = 16,
  parameter int PULSE_LEN = 25000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_a_pin,
  input  logic             det_b_pin,
  input  logic             rdy_pin,
  input  logic             io_rdy_pin,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             card_present,
  output logic             det_event,
  output logic             card_rst,
  output logic [1:0]       card_mode,
  output logic             host_en
);
  logic [NUM_DET-1:0] det_raw;
  logic [NUM_DET-1:0] det_lvl;
  logic [NUM_DET-1:0] det_settled;
  logic [1:0]         rdy_s;
  ctrl_t              ctl;
  logic               ctl_hold;
  logic               chg_flag;
  logic               ctl_wr;
  logic               st_wr;
  logic               dis_wr;
  logic               pulse_req;

  assign det_raw = {det_b_pin, det_a_pin};

  for (genvar i = 0; i < NUM_DET; i++) begin : g_det
    cfdr_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_raw (det_raw[i]),
      .level   (det_lvl[i]),
      .settled (det_settled[i])
    );
  end

  cfdr_sync2 #(.W(2), .RST_VAL(2'b00)) u_rdy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({io_rdy_pin, rdy_pin}),
    .q     (rdy_s)
  );

  cfdr_presence #(.N(NUM_DET)) u_pres (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (det_lvl),
    .settled (det_settled),
    .host_en (ctl.host_en),
    .present (card_present),
    .event_p (det_event)
  );

  assign ctl_wr = reg_we & reg_sel;
  assign st_wr  = reg_we & ~reg_sel;
  assign dis_wr = ctl_wr & ~reg_wdata[CT_HOST_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '{host_en: 1'b0, hold: 1'b0, mode: MODE_MEMORY};
    end else if (ctl_wr) begin
      ctl.host_en <= reg_wdata[CT_HOST_EN];
      ctl.hold    <= reg_wdata[CT_HOLD];
      ctl.mode    <= card_mode_e'(reg_wdata[CT_MODE_LO +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_flag <= 1'b0;
    end else if (!ctl.host_en || dis_wr) begin
      chg_flag <= 1'b0;
    end else if (det_event) begin
      chg_flag <= 1'b1;
    end else if (st_wr && reg_wdata[ST_CHANGED]) begin
      chg_flag <= 1'b0;
    end
  end

  assign pulse_req = (ctl_wr && reg_wdata[CT_PULSE] && reg_wdata[CT_HOST_EN])
                   || (det_event && card_present);

  assign ctl_hold = ctl.hold;

  cfdr_rst_gen #(.PULSE_LEN(PULSE_LEN)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .enabled (ctl.host_en),
    .abort   (dis_wr),
    .start   (pulse_req),
    .hold    (ctl_hold),
    .rst_out (card_rst)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[CT_MODE_LO +: 2] = ctl.mode;
      reg_rdata[CT_HOLD]         = ctl.hold;
      reg_rdata[CT_HOST_EN]      = ctl.host_en;
    end else begin
      reg_rdata[ST_CHANGED] = chg_flag;
      reg_rdata[ST_DET_A]   = det_lvl[0];
      reg_rdata[ST_DET_B]   = det_lvl[1];
      reg_rdata[ST_READY]   = rdy_s[0];
      reg_rdata[ST_IO_RDY]  = rdy_s[1];
    end
  end

  assign card_mode = ctl.mode;
  assign host_en   = ctl.host_en;
endmodule

// File: rtl/cfdr_checker.sv
module cfdr_checker #(
  parameter int PULSE_LEN = 25000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_en,
  input logic       hold,
  input logic       card_present,
  input logic       det_event,
  input logic       card_rst,
  input logic       reg_we,
  input logic       reg_sel,
  input logic [7:0] reg_wdata
);
  int unsigned rst_run;
  logic        restart;

  assign restart = (reg_we && reg_sel && reg_wdata[7]) || det_event;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_run <= 0;
    end else if (restart) begin
      rst_run <= 1;
    end else if (card_rst && !hold) begin
      rst_run <= rst_run + 1;
    end else begin
      rst_run <= 0;
    end
  end

  AST_EVENT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    det_event |-> (card_present != $past(card_present))) else $error("event without change"); // R3

  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    det_event |=> !det_event) else $error("event longer than one cycle"); // R3

  AST_EVENT_NEEDS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    det_event |-> $past(host_en)) else $error("event while host disabled"); // R10

  AST_HOST_OFF_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_en && !hold) |-> !card_rst) else $error("pulse while host disabled"); // R10

  AST_HOLD_FORCES_RST: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> card_rst) else $error("hold not driving reset"); // R7

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rst && !hold) |-> (rst_run <= PULSE_LEN)) else $error("pulse too long"); // R8
endmodule

bind cf_detect_reset cfdr_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_en      (host_en),
  .hold         (ctl_hold),
  .card_present (card_present),
  .det_event    (det_event),
  .card_rst     (card_rst),
  .reg_we       (reg_we),
  .reg_sel      (reg_sel),
  .reg_wdata    (reg_wdata)
);

// File: tb/tb_cf_detect_reset.sv
`timescale 1ns/1ps
module tb_cf_detect_reset;
  localparam int FILT = 8;
  localparam int PLEN = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       det_a_pin = 1'b0, det_b_pin = 1'b0;
  logic       rdy_pin = 1'b1, io_rdy_pin = 1'b0;
  logic       reg_sel = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       card_present, det_event, card_rst, host_en;
  logic [1:0] card_mode;

  int errors = 0;
  int checks = 0;
  bit exp_q[$];

  always #4 clk = ~clk;

  cf_detect_reset #(.FILT_LEN(FILT), .PULSE_LEN(PLEN)) dut (
    .clk(clk), .rst_n(rst_n), .det_a_pin(det_a_pin), .det_b_pin(det_b_pin),
    .rdy_pin(rdy_pin), .io_rdy_pin(io_rdy_pin), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .card_present(card_present), .det_event(det_event), .card_rst(card_rst),
    .card_mode(card_mode), .host_en(host_en)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // monitor: pops the expected present state for each event
  always @(negedge clk) begin
    if (rst_n && det_event) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected event", 1, 0);
      end else begin
        check("R3 event state", int'(card_present), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic measure(output int len);
    int t;
    len = 0;
    t = 0;
    while (!card_rst && t < 200) begin
      @(negedge clk);
      t++;
    end
    while (card_rst) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int len;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(30);
    // R4 priming from seated pins, no event
    check("R4 present after reset", card_present, 1);
    check("R4 rst low", card_rst, 0);
    rd(1'b0, r); check("R5 status after reset", r, 8'h20);
    rd(1'b1, r); check("R4 control reset", r, 8'h00);

    wr(1'b1, 8'h12);
    rd(1'b1, r); check("R7 control readback", r, 8'h12);
    check("R7 card_mode", card_mode, 2);
    check("R7 host_en", host_en, 1);

    // removal of contact A
    exp_q.push_back(1'b0);
    det_a_pin = 1'b1;
    wait_cyc(30);
    check("R1 absent with A high", card_present, 0);
    check("R9 no pulse on removal", card_rst, 0);
    rd(1'b0, r); check("R6 flag set", r, 8'h25);
    wr(1'b0, 8'h00);
    rd(1'b0, r); check("R6 write zero keeps flag", r, 8'h25);
    wr(1'b0, 8'h01);
    rd(1'b0, r); check("R6 W1C clears flag", r, 8'h24);

    // same state: B high too
    det_b_pin = 1'b1;
    wait_cyc(30);
    check("R3 still absent", card_present, 0);
    rd(1'b0, r); check("R5 both pins high", r, 8'h2C);
    det_a_pin = 1'b0;
    wait_cyc(30);
    check("R1 absent with B high", card_present, 0);

    // glitch on B shorter than filter
    det_b_pin = 1'b0;
    wait_cyc(4);
    det_b_pin = 1'b1;
    wait_cyc(30);
    check("R2 glitch ignored", card_present, 0);
    rd(1'b0, r); check("R2 status pins unchanged", r, 8'h28);

    // insertion with automatic pulse
    exp_q.push_back(1'b1);
    det_b_pin = 1'b0;
    measure(len);
    check("R9 insertion pulse length", len, PLEN);
    check("R1 present both low", card_present, 1);
    rd(1'b0, r); check("R6 flag on insertion", r, 8'h21);

    // software pulse
    wr(1'b1, 8'h92);
    measure(len);
    check("R8 software pulse length", len, PLEN);
    rd(1'b1, r); check("R8 go bit reads zero", r, 8'h12);

    // hold
    wr(1'b1, 8'h1A);
    wait_cyc(50);
    check("R7 hold keeps reset", card_rst, 1);
    wr(1'b1, 8'h12);
    check("R7 release hold", card_rst, 0);

    // host disabled
    wr(1'b1, 8'h02);
    rd(1'b0, r); check("R10 flag cleared on disable", r, 8'h20);
    det_a_pin = 1'b1;
    wait_cyc(30);
    check("R10 present tracks while disabled", card_present, 0);
    rd(1'b0, r); check("R10 no flag while disabled", r, 8'h24);
    det_a_pin = 1'b0;
    measure(len);
    check("R10 no insertion pulse", len, 0);
    check("R10 present", card_present, 1);
    wr(1'b1, 8'h82);
    measure(len);
    check("R10 pulse request ignored", len, 0);

    // abort running pulse
    wr(1'b1, 8'h12);
    wr(1'b1, 8'h92);
    wait_cyc(5);
    check("R8 pulse running", card_rst, 1);
    wr(1'b1, 8'h02);
    check("R10 pulse aborted", card_rst, 0);

    // ready pins
    rdy_pin = 1'b0;
    io_rdy_pin = 1'b1;
    wait_cyc(10);
    rd(1'b0, r); check("R5 ready bits", r, 8'h40);

    wr(1'b1, 8'h11);
    check("R7 mode io", card_mode, 1);
    rd(1'b1, r); check("R7 mode readback", r, 8'h11);

    wait_cyc(5);
    check("R3 all events seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule